// File: doc/BRIEF.md
# Multi-queue free buffer allocator

This block hands out free data buffers on demand from 32 independent circular queues that live in a shared memory. Each queue has a small configuration record kept inside the block: the base address of its ring, a 2-bit depth code, a buffer length in bytes, the address where its read index is published, a pop interval, the current read index, an empty flag and a pop counter. A client names a queue. The block reads the two-word ring entry at that queue's read index and checks its valid bit. If the entry is valid, the block clears the valid bit in memory, advances the index and grants the buffer descriptor pointer, the data buffer pointer and the queue's buffer length.

Every time the configured number of pops has been taken from a queue, the block writes that queue's new read index to the queue's publish address. Host software can then see how far the ring has been consumed and refill it. A global input turns underflow protection off. With protection on, finding an invalid entry latches the queue's empty flag, and later requests to that queue fail at once until the host clears the flag. Only one request is in flight at a time. Memory reads and writes use a valid/ready handshake, and reads return on a separate response strobe.

Top module: `fbq_alloc`

## Requirements
- R1: After reset, req_ready is 1, grant_valid is 0, mem_req_valid is 0, and every configuration field reads back 0.
- R2: The depth code sets the ring size: 0 gives 64 entries, 1 gives 256, 2 gives 1024 and 3 gives 4096. A pop at index depth-1 wraps the read index to 0.
- R3: The ring entry at index i starts at byte address base+8*i. Word 0 carries the descriptor pointer in bits 31:1 and the valid bit in bit 0. Word 1, at base+8*i+4, is the data buffer pointer. The granted descriptor pointer is word 0 with bit 0 forced to 0.
- R4: A pop from a valid entry grants with grant_ok=1, the descriptor pointer, the buffer pointer and the queue's length. It writes word 0 back with bit 0 cleared and advances the read index by one.
- R5: A pop that meets an invalid entry grants with grant_ok=0 and zero pointers. It leaves the read index and the pop counter unchanged and makes no memory write.
- R6: With protection on (prot_dis=0), an invalid entry sets the queue's empty flag. While that flag is set, requests to the queue fail with no memory access.
- R7: With protection off (prot_dis=1), an invalid entry does not set the empty flag. A set flag is ignored, and the entry is still read from memory.
- R8: When a successful pop brings the pop counter up to the interval (an interval of 0 acts as 1), the new read index, zero-extended, is written to the publish address and the counter returns to 0. Writing the index field also clears the counter.
- R9: Each memory request holds its address, data and direction stable until it is accepted. req_ready is high only when the block is idle, and grant_valid lasts exactly one cycle.
- R10: grant_qid equals the queue number of the request being answered.
- R11: Configuration selector codes are: 0 ring base, 1 depth code in bits 1:0 with interval in bits 15:8, 2 publish address, 3 length, 4 read index in bits 11:0 with empty flag in bit 16, and 5 pop counter (read only). cfg_rdata shows the field chosen by cfg_qid and cfg_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_dis | input | 1 | 1 turns off underflow protection |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_qid | input | 5 | Queue selected for configuration access |
| cfg_sel | input | 3 | Field selector |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected field value |
| req_valid | input | 1 | Client pop request |
| req_qid | input | 5 | Queue to pop |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| grant_valid | output | 1 | One-cycle grant strobe |
| grant_ok | output | 1 | 1 when a buffer was handed out |
| grant_qid | output | 5 | Queue answered |
| grant_bd_ptr | output | 32 | Buffer descriptor pointer |
| grant_buf_ptr | output | 32 | Data buffer pointer |
| grant_len | output | 16 | Buffer length in bytes |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 for write, 0 for read |
| mem_req_addr | output | 32 | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
The bench drives pops at the last index of each depth code. A wrong mask would either fail to wrap or wrap early, and the read-back index would come out nonzero. It hits invalid entries with protection both on and off. A design that latches the flag regardless, or that still reads memory for a queue already marked empty, shows an unexpected empty bit or a nonzero read count. It checks the publish write on every pop, including interval 0, and counts memory writes per pop. An off-by-one counter, a stale index in the publish word, or a spurious write on a failed pop all show up as mismatches. A random memory-ready and response latency shakes out any request that changes before it is accepted.

// File: rtl/fbq_pkg.sv
package fbq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_WT0,
        ST_RD1,
        ST_WT1,
        ST_CLR,
        ST_WB,
        ST_GNT
    } fbq_state_e;

    localparam logic [2:0] SEL_BASE  = 3'd0;
    localparam logic [2:0] SEL_SHAPE = 3'd1;
    localparam logic [2:0] SEL_PUB   = 3'd2;
    localparam logic [2:0] SEL_LEN   = 3'd3;
    localparam logic [2:0] SEL_INDEX = 3'd4;
    localparam logic [2:0] SEL_CNT   = 3'd5;

endpackage

// File: rtl/fbq_cfg_table.sv
module fbq_cfg_table
    import fbq_pkg::*;
#(
    parameter int NQ     = 32,
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int LW     = 16,
    parameter int CW     = 8,
    parameter int MINLOG = 6,
    localparam int QW    = $clog2(NQ),
    localparam int IW    = MINLOG + 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [QW-1:0] cfg_qid,
    input  logic [2:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic [QW-1:0] lk_qid,
    output logic [AW-1:0] lk_base,
    output logic [1:0]    lk_code,
    output logic [CW-1:0] lk_ivl,
    output logic [AW-1:0] lk_pub,
    output logic [LW-1:0] lk_len,
    output logic [IW-1:0] lk_idx,
    output logic          lk_empty,
    output logic [CW-1:0] lk_cnt,
    input  logic          upd_valid,
    input  logic [QW-1:0] upd_qid,
    input  logic [IW-1:0] upd_idx,
    input  logic [CW-1:0] upd_cnt,
    input  logic          upd_set_empty
);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [1:0]    code;
        logic [CW-1:0] ivl;
        logic [AW-1:0] pub;
        logic [LW-1:0] len;
        logic [IW-1:0] idx;
        logic          empty;
        logic [CW-1:0] cnt;
    } rec_t;

    rec_t tab_q [NQ];
    rec_t tab_d [NQ];

    always_comb begin
        tab_d = tab_q;
        if (upd_valid) begin
            tab_d[upd_qid].idx = upd_idx;
            tab_d[upd_qid].cnt = upd_cnt;
            if (upd_set_empty) begin
                tab_d[upd_qid].empty = 1'b1;
            end
        end
        if (cfg_we) begin
            case (cfg_sel)
                SEL_BASE:  tab_d[cfg_qid].base = cfg_wdata[AW-1:0];
                SEL_SHAPE: begin
                    tab_d[cfg_qid].code = cfg_wdata[1:0];
                    tab_d[cfg_qid].ivl  = cfg_wdata[8 +: CW];
                end
                SEL_PUB:   tab_d[cfg_qid].pub = cfg_wdata[AW-1:0];
                SEL_LEN:   tab_d[cfg_qid].len = cfg_wdata[LW-1:0];
                SEL_INDEX: begin
                    tab_d[cfg_qid].idx   = cfg_wdata[IW-1:0];
                    tab_d[cfg_qid].empty = cfg_wdata[16];
                    tab_d[cfg_qid].cnt   = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NQ; i++) begin
                tab_q[i] <= '0;
            end
        end else begin
            tab_q <= tab_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            SEL_BASE:  cfg_rdata = DW'(tab_q[cfg_qid].base);
            SEL_SHAPE: begin
                cfg_rdata[1:0]      = tab_q[cfg_qid].code;
                cfg_rdata[8 +: CW]  = tab_q[cfg_qid].ivl;
            end
            SEL_PUB:   cfg_rdata = DW'(tab_q[cfg_qid].pub);
            SEL_LEN:   cfg_rdata = DW'(tab_q[cfg_qid].len);
            SEL_INDEX: begin
                cfg_rdata[IW-1:0] = tab_q[cfg_qid].idx;
                cfg_rdata[16]     = tab_q[cfg_qid].empty;
            end
            SEL_CNT:   cfg_rdata = DW'(tab_q[cfg_qid].cnt);
            default:   cfg_rdata = '0;
        endcase
    end

    assign lk_base  = tab_q[lk_qid].base;
    assign lk_code  = tab_q[lk_qid].code;
    assign lk_ivl   = tab_q[lk_qid].ivl;
    assign lk_pub   = tab_q[lk_qid].pub;
    assign lk_len   = tab_q[lk_qid].len;
    assign lk_idx   = tab_q[lk_qid].idx;
    assign lk_empty = tab_q[lk_qid].empty;
    assign lk_cnt   = tab_q[lk_qid].cnt;

    AST_CNT_CLEARED_BY_INDEX_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_INDEX && !upd_valid) |=> (tab_q[$past(cfg_qid)].cnt == '0)); // R8

endmodule

// File: rtl/fbq_engine.sv
module fbq_engine
    import fbq_pkg::*;
#(
    parameter int NQ     = 32,
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int LW     = 16,
    parameter int CW     = 8,
    parameter int MINLOG = 6,
    localparam int QW    = $clog2(NQ),
    localparam int IW    = MINLOG + 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prot_dis,
    input  logic          req_valid,
    input  logic [QW-1:0] req_qid,
    output logic          req_ready,
    output logic          grant_valid,
    output logic          grant_ok,
    output logic [QW-1:0] grant_qid,
    output logic [DW-1:0] grant_bd_ptr,
    output logic [DW-1:0] grant_buf_ptr,
    output logic [LW-1:0] grant_len,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_we,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_rdata,
    output logic [QW-1:0] lk_qid,
    input  logic [AW-1:0] lk_base,
    input  logic [1:0]    lk_code,
    input  logic [CW-1:0] lk_ivl,
    input  logic [AW-1:0] lk_pub,
    input  logic [LW-1:0] lk_len,
    input  logic [IW-1:0] lk_idx,
    input  logic          lk_empty,
    input  logic [CW-1:0] lk_cnt,
    output logic          upd_valid,
    output logic [QW-1:0] upd_qid,
    output logic [IW-1:0] upd_idx,
    output logic [CW-1:0] upd_cnt,
    output logic          upd_set_empty
);

    typedef struct packed {
        fbq_state_e    st;
        logic [QW-1:0] qid;
        logic [DW-1:0] bd;
        logic [DW-1:0] bp;
        logic          ok;
        logic [IW-1:0] nidx;
        logic [CW-1:0] ncnt;
        logic          set_empty;
    } eng_t;

    eng_t s_q, s_d;

    logic [2:0]    shamt;
    logic [IW-1:0] mask;
    logic [AW-1:0] ent_addr;
    logic [CW-1:0] ivl_eff;
    logic [CW-1:0] cnt_inc;
    logic          pub_due;

    always_comb begin
        shamt    = {2'd3 - lk_code, 1'b0};
        mask     = {IW{1'b1}} >> shamt;
        ent_addr = lk_base + AW'({lk_idx, 3'b000});
        ivl_eff  = (lk_ivl == '0) ? CW'(1) : lk_ivl;
        cnt_inc  = lk_cnt + CW'(1);
        pub_due  = (cnt_inc >= ivl_eff);
    end

    assign lk_qid = (s_q.st == ST_IDLE) ? req_qid : s_q.qid;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_IDLE: begin
                s_d.ok        = 1'b0;
                s_d.set_empty = 1'b0;
                if (req_valid) begin
                    s_d.qid = req_qid;
                    if (!prot_dis && lk_empty) begin
                        s_d.st = ST_GNT;
                    end else begin
                        s_d.st = ST_RD0;
                    end
                end
            end
            ST_RD0: begin
                if (mem_req_ready) begin
                    s_d.st = ST_WT0;
                end
            end
            ST_WT0: begin
                if (mem_rsp_valid) begin
                    s_d.bd = mem_rsp_rdata;
                    if (mem_rsp_rdata[0]) begin
                        s_d.st = ST_RD1;
                    end else begin
                        s_d.st        = ST_GNT;
                        s_d.set_empty = !prot_dis;
                    end
                end
            end
            ST_RD1: begin
                if (mem_req_ready) begin
                    s_d.st = ST_WT1;
                end
            end
            ST_WT1: begin
                if (mem_rsp_valid) begin
                    s_d.bp = mem_rsp_rdata;
                    s_d.st = ST_CLR;
                end
            end
            ST_CLR: begin
                if (mem_req_ready) begin
                    s_d.ok   = 1'b1;
                    s_d.nidx = (lk_idx + IW'(1)) & mask;
                    s_d.ncnt = pub_due ? '0 : cnt_inc;
                    s_d.st   = pub_due ? ST_WB : ST_GNT;
                end
            end
            ST_WB: begin
                if (mem_req_ready) begin
                    s_d.st = ST_GNT;
                end
            end
            ST_GNT: begin
                s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        case (s_q.st)
            ST_RD0: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = ent_addr;
            end
            ST_RD1: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = ent_addr + AW'(4);
            end
            ST_CLR: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = ent_addr;
                mem_req_wdata = {s_q.bd[DW-1:1], 1'b0};
            end
            ST_WB: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = lk_pub;
                mem_req_wdata = DW'(s_q.nidx);
            end
            default: ;
        endcase
    end

    assign req_ready     = (s_q.st == ST_IDLE);
    assign grant_valid   = (s_q.st == ST_GNT);
    assign grant_ok      = grant_valid && s_q.ok;
    assign grant_qid     = s_q.qid;
    assign grant_bd_ptr  = grant_ok ? {s_q.bd[DW-1:1], 1'b0} : '0;
    assign grant_buf_ptr = grant_ok ? s_q.bp : '0;
    assign grant_len     = grant_ok ? lk_len : '0;

    assign upd_valid     = (s_q.st == ST_GNT);
    assign upd_qid       = s_q.qid;
    assign upd_idx       = s_q.ok ? s_q.nidx : lk_idx;
    assign upd_cnt       = s_q.ok ? s_q.ncnt : lk_cnt;
    assign upd_set_empty = s_q.set_empty;

    AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |=> !grant_valid); // R9

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata))); // R9

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid || mem_req_valid) |-> !req_ready); // R9

    AST_IDX_IN_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> ((upd_idx & ~mask) == '0)); // R2

    AST_EMPTY_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !prot_dis && lk_empty) |=> (!mem_req_valid && grant_valid && !grant_ok)); // R6

    AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && s_q.st == ST_WT0 && !mem_rsp_rdata[0]) |=> (grant_valid && !mem_req_valid)); // R5

endmodule

// File: rtl/fbq_alloc.sv
module fbq_alloc
    import fbq_pkg::*;
#(
    parameter int NQ     = 32,
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int LW     = 16,
    parameter int CW     = 8,
    parameter int MINLOG = 6,
    localparam int QW    = $clog2(NQ),
    localparam int IW    = MINLOG + 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prot_dis,
    input  logic          cfg_we,
    input  logic [QW-1:0] cfg_qid,
    input  logic [2:0]    cfg_sel,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          req_valid,
    input  logic [QW-1:0] req_qid,
    output logic          req_ready,
    output logic          grant_valid,
    output logic          grant_ok,
    output logic [QW-1:0] grant_qid,
    output logic [DW-1:0] grant_bd_ptr,
    output logic [DW-1:0] grant_buf_ptr,
    output logic [LW-1:0] grant_len,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_we,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_rdata
);

    logic [QW-1:0] lk_qid;
    logic [AW-1:0] lk_base;
    logic [1:0]    lk_code;
    logic [CW-1:0] lk_ivl;
    logic [AW-1:0] lk_pub;
    logic [LW-1:0] lk_len;
    logic [IW-1:0] lk_idx;
    logic          lk_empty;
    logic [CW-1:0] lk_cnt;
    logic          upd_valid;
    logic [QW-1:0] upd_qid;
    logic [IW-1:0] upd_idx;
    logic [CW-1:0] upd_cnt;
    logic          upd_set_empty;

    fbq_cfg_table #(
        .NQ(NQ), .AW(AW), .DW(DW), .LW(LW), .CW(CW), .MINLOG(MINLOG)
    ) u_table (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_qid       (cfg_qid),
        .cfg_sel       (cfg_sel),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .lk_qid        (lk_qid),
        .lk_base       (lk_base),
        .lk_code       (lk_code),
        .lk_ivl        (lk_ivl),
        .lk_pub        (lk_pub),
        .lk_len        (lk_len),
        .lk_idx        (lk_idx),
        .lk_empty      (lk_empty),
        .lk_cnt        (lk_cnt),
        .upd_valid     (upd_valid),
        .upd_qid       (upd_qid),
        .upd_idx       (upd_idx),
        .upd_cnt       (upd_cnt),
        .upd_set_empty (upd_set_empty)
    );

    fbq_engine #(
        .NQ(NQ), .AW(AW), .DW(DW), .LW(LW), .CW(CW), .MINLOG(MINLOG)
    ) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .prot_dis      (prot_dis),
        .req_valid     (req_valid),
        .req_qid       (req_qid),
        .req_ready     (req_ready),
        .grant_valid   (grant_valid),
        .grant_ok      (grant_ok),
        .grant_qid     (grant_qid),
        .grant_bd_ptr  (grant_bd_ptr),
        .grant_buf_ptr (grant_buf_ptr),
        .grant_len     (grant_len),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_we    (mem_req_we),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata),
        .lk_qid        (lk_qid),
        .lk_base       (lk_base),
        .lk_code       (lk_code),
        .lk_ivl        (lk_ivl),
        .lk_pub        (lk_pub),
        .lk_len        (lk_len),
        .lk_idx        (lk_idx),
        .lk_empty      (lk_empty),
        .lk_cnt        (lk_cnt),
        .upd_valid     (upd_valid),
        .upd_qid       (upd_qid),
        .upd_idx       (upd_idx),
        .upd_cnt       (upd_cnt),
        .upd_set_empty (upd_set_empty)
    );

endmodule

// File: tb/sim_fbq_alloc.sv
`timescale 1ns/1ps
module sim_fbq_alloc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prot_dis = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_qid = '0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [4:0]  req_qid = '0;
    logic        req_ready;
    logic        grant_valid, grant_ok;
    logic [4:0]  grant_qid;
    logic [31:0] grant_bd_ptr, grant_buf_ptr;
    logic [15:0] grant_len;
    logic        mem_req_valid, mem_req_we;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;

    always #4 clk = ~clk;

    fbq_alloc u0 (.*);

    logic [31:0] mem [16384];
    int rd_cnt = 0, wr_cnt = 0, pub_cnt = 0;
    logic [31:0] pub_data = '0, pub_addr = '0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;
    int          pend_dly = 0;

    function automatic int widx(input logic [31:0] a);
        return int'(a[15:2]);
    endfunction

    always @(posedge clk) begin
        mem_req_ready <= ($urandom % 4) != 0;
        mem_rsp_valid <= 1'b0;
        if (pend) begin
            if (pend_dly == 0) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= mem[widx(pend_addr)];
                pend <= 1'b0;
            end else begin
                pend_dly <= pend_dly - 1;
            end
        end
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                mem[widx(mem_req_addr)] <= mem_req_wdata;
                wr_cnt <= wr_cnt + 1;
                if (mem_req_addr[15:12] == 4'hF) begin
                    pub_cnt  <= pub_cnt + 1;
                    pub_data <= mem_req_wdata;
                    pub_addr <= mem_req_addr;
                end
            end else begin
                rd_cnt    <= rd_cnt + 1;
                pend      <= 1'b1;
                pend_addr <= mem_req_addr;
                pend_dly  <= int'($urandom % 3);
            end
        end
    end

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    int m_base[32], m_code[32], m_ivl[32], m_pub[32], m_len[32];
    int m_idx[32], m_cnt[32];
    bit m_empty[32];

    function automatic int depth_of(input int code);
        return 64 << (2 * code);
    endfunction

    task automatic cfg_wr(input int q, input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_qid = 5'(q); cfg_sel = 3'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input int q, input int sel, output logic [31:0] d);
        @(negedge clk);
        cfg_qid = 5'(q); cfg_sel = 3'(sel);
        #1 d = cfg_rdata;
    endtask

    task automatic setup_q(input int q, input int base, input int code, input int ivl, input int len);
        m_base[q] = base; m_code[q] = code; m_ivl[q] = ivl; m_pub[q] = 32'hF000 + 4 * q;
        m_len[q] = len; m_idx[q] = 0; m_cnt[q] = 0; m_empty[q] = 1'b0;
        cfg_wr(q, 0, 32'(base));
        cfg_wr(q, 1, 32'((ivl << 8) | code));
        cfg_wr(q, 2, 32'(m_pub[q]));
        cfg_wr(q, 3, 32'(len));
        cfg_wr(q, 4, 32'h0);
    endtask

    task automatic put_entry(input int q, input int i, input bit v);
        logic [31:0] a;
        a = 32'(m_base[q] + 8 * i);
        mem[widx(a)]     = {$urandom() & 32'hFFFF_FFFE} | {31'b0, v};
        mem[widx(a) + 1] = $urandom();
    endtask

    task automatic set_index(input int q, input int idx, input bit emp);
        m_idx[q] = idx; m_cnt[q] = 0; m_empty[q] = emp;
        cfg_wr(q, 4, 32'(idx) | (32'(emp) << 16));
    endtask

    // one pop, predicted from the bench model and checked at the ports
    task automatic pop_check(input int q);
        logic [31:0] w0, w1, a, rb;
        bit exp_ok, exp_rd, pub;
        int rd0, wr0, pub0, ivl_e;
        a  = 32'(m_base[q] + 8 * m_idx[q]);
        w0 = mem[widx(a)];
        w1 = mem[widx(a) + 1];
        exp_rd = prot_dis || !m_empty[q];
        exp_ok = exp_rd && w0[0];
        ivl_e  = (m_ivl[q] == 0) ? 1 : m_ivl[q];
        pub    = exp_ok && (m_cnt[q] + 1 >= ivl_e);
        rd0 = rd_cnt; wr0 = wr_cnt; pub0 = pub_cnt;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_qid = 5'(q);
        @(negedge clk);
        req_valid = 1'b0;
        while (!grant_valid) @(negedge clk);
        chk("R10 grant_qid", 32'(grant_qid), 32'(q));
        chk(exp_ok ? "R4 grant_ok" : "R5 grant_ok", 32'(grant_ok), 32'(exp_ok));
        if (exp_ok) begin
            chk("R3 bd_ptr", grant_bd_ptr, w0 & 32'hFFFF_FFFE);
            chk("R3 buf_ptr", grant_buf_ptr, w1);
            chk("R4 len", 32'(grant_len), 32'(m_len[q]));
        end else begin
            chk("R5 zero bd", grant_bd_ptr, 32'h0);
            chk("R5 zero buf", grant_buf_ptr, 32'h0);
        end
        @(negedge clk);
        chk(exp_rd ? "R7 reads" : "R6 no reads", 32'(rd_cnt - rd0), exp_ok ? 32'd2 : 32'(exp_rd));
        chk(exp_ok ? "R4 writes" : "R5 no writes", 32'(wr_cnt - wr0), exp_ok ? 32'(1 + pub) : 32'd0);
        if (exp_ok) begin
            chk("R4 valid cleared", 32'(mem[widx(a)][0]), 32'h0);
            m_idx[q] = (m_idx[q] + 1) % depth_of(m_code[q]);
            m_cnt[q] = pub ? 0 : m_cnt[q] + 1;
        end else if (exp_rd && !prot_dis) begin
            m_empty[q] = 1'b1;
        end
        chk("R8 publish count", 32'(pub_cnt - pub0), 32'(pub));
        if (pub) begin
            chk("R8 publish data", pub_data, 32'(m_idx[q]));
            chk("R8 publish addr", pub_addr, 32'(m_pub[q]));
        end
        cfg_rd(q, 4, rb);
        chk("R2 index/empty", rb, 32'(m_idx[q]) | (32'(m_empty[q]) << 16));
        cfg_rd(q, 5, rb);
        chk("R8 counter", rb, 32'(m_cnt[q]));
    endtask

    initial begin
        logic [31:0] rb;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16384; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 req_ready", 32'(req_ready), 32'h1);
        chk("R1 grant_valid", 32'(grant_valid), 32'h0);
        chk("R1 mem_req_valid", 32'(mem_req_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req_ready", 32'(req_ready), 32'h1);
        for (int s = 0; s < 6; s++) begin
            cfg_rd(7, s, rb);
            chk("R1 field zero", rb, 32'h0);
        end

        // ring queues 0..7, depth code 0
        for (int q = 0; q < 8; q++) begin
            setup_q(q, q * 32'h200, 0, (q == 0) ? 0 : 1 + (q % 5), 64 * (q + 1));
            for (int i = 0; i < 64; i++) put_entry(q, i, ($urandom % 100) < 85);
        end
        cfg_rd(3, 1, rb);
        chk("R11 shape readback", rb, 32'((4 << 8) | 0));
        cfg_rd(3, 2, rb);
        chk("R11 publish readback", rb, 32'hF00C);

        // deep depth codes: pop at last index must wrap to 0
        setup_q(12, 32'h1000, 1, 2, 100);
        setup_q(13, 32'h2000, 2, 3, 200);
        setup_q(14, 32'h4000, 3, 1, 300);
        for (int q = 12; q < 15; q++) begin
            set_index(q, depth_of(m_code[q]) - 1, 1'b0);
            put_entry(q, m_idx[q], 1'b1);
            put_entry(q, 0, 1'b1);
            pop_check(q);
            chk("R2 wrapped", 32'(m_idx[q]), 32'h0);
            pop_check(q);
        end

        // R7: protection off, invalid entry does not latch empty
        prot_dis = 1'b1;
        setup_q(20, 32'h3800, 0, 1, 40);
        put_entry(20, 0, 1'b0);
        pop_check(20);
        pop_check(20);
        // R6: protection on, invalid latches empty and later requests skip memory
        prot_dis = 1'b0;
        pop_check(20);
        put_entry(20, 0, 1'b1);
        pop_check(20);
        // R7: with protection off a set flag is ignored
        prot_dis = 1'b1;
        pop_check(20);
        prot_dis = 1'b0;

        // random traffic
        for (int n = 0; n < 400; n++) begin
            int q;
            q = int'($urandom % 8);
            if ((n % 50) == 0) prot_dis = ($urandom % 3) == 0;
            if (($urandom % 20) == 0) begin
                for (int i = 0; i < 64; i++) put_entry(q, i, ($urandom % 100) < 90);
                set_index(q, m_idx[q], 1'b0);
            end
            pop_check(q);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule